// File: doc/BRIEF.md
# Hashed Page Table Lookup Engine

This block translates a virtual page number into a physical frame number by searching a hashed page table kept in memory. The page number is folded into a bucket index, and the engine reads that bucket's head pointer from a table of one-word heads at a fixed base address. It then walks the chain of elements that starts at the head. Each element holds a page number, a frame number and a link to the next element. The walk ends at the first element whose page number equals the request, or at a zero link.

The engine has one request port and one response port toward the translation logic. It reaches memory through a single read port that allows one outstanding read. It works on one lookup at a time. The response is a single-cycle pulse carrying hit, error and frame. A limit on the number of elements visited protects the engine against a corrupted chain that loops back on itself.

Top module: `hpt_walker`

## Requirements
- R1: While reset is held and just after it is released, `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0.
- R2: The first read of a lookup is at address `TABLE_BASE + 4*h`. Here `h` is the upper half of the page number XOR the lower half (each half `VPN_W/2` bits wide), reduced to its low `BKT_W` bits.
- R3: An element at byte address `p` occupies three 32-bit words. The word at `p` holds the page number, the word at `p+4` holds the frame and the word at `p+8` holds the next pointer. Only the low `VPN_W` bits of the page word and the low `PFN_W` bits of the frame word are used.
- R4: When the stored page number of a visited element equals the request, the response has `resp_hit`=1, `resp_err`=0 and `resp_pfn` equal to that element's frame. The frame word is the last read of the lookup.
- R5: For an element whose page number does not match, the engine reads the page word and then the next word. It never reads that element's frame word.
- R6: A head pointer or a next pointer equal to zero ends the walk as a miss, with `resp_hit`=0, `resp_err`=0 and `resp_pfn`=0.
- R7: At most `MAX_HOPS` elements are visited. If the element at position `MAX_HOPS` does not match and its next pointer is nonzero, the response has `resp_err`=1, `resp_hit`=0 and `resp_pfn`=0. A match at position `MAX_HOPS` is still a hit.
- R8: From the cycle a request is accepted until its response, `req_ready` is 0. Requests presented during that time are ignored, and the response belongs to the accepted page number.
- R9: While `mem_req` is 1 and no read data has returned, `mem_addr` holds its value.
- R10: `resp_valid` is high for exactly one cycle per lookup, and `req_ready` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request taken when both high |
| req_vpn | input | VPN_W | Virtual page number to translate |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_hit | output | 1 | Translation found |
| resp_err | output | 1 | Walk exceeded the element limit |
| resp_pfn | output | PFN_W | Frame number on a hit, zero otherwise |
| mem_req | output | 1 | Read request, held until data returns |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The bench builds the engine with a 20-bit page number, 16 buckets, a limit of 6 elements and a table base of 0x40. Sixteen buckets make collisions common, so random tables produce chains long enough to hit the element limit. They also make it simple to build page numbers that share a bucket for the directed chains. These include chains that match exactly at the limit, chains that end in a null link exactly at the limit, chains one element too long, and a self-referencing element. The bench memory answers after a random delay, so every held-address and ordering rule is exercised under varying latency.

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int BKT_W = 8,
  parameter int MAX_HOPS = 32,
  parameter logic [31:0] TABLE_BASE = 32'h0010_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_err,
  output logic [PFN_W-1:0] resp_pfn,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata
);

  localparam int HALF  = VPN_W / 2;
  localparam int HOP_W = $clog2(MAX_HOPS + 1);

  typedef enum logic [2:0] {S_IDLE, S_HEAD, S_VPN, S_PFN, S_NEXT} st_t;

  st_t              st;
  logic [VPN_W-1:0] vpn_q;
  logic [31:0]      ptr_q;
  logic [HOP_W-1:0] hops_q;

  logic [VPN_W-1:0] fold;
  logic [BKT_W-1:0] bkt;
  logic [31:0]      head_addr;
  logic             vpn_eq, link_null, at_limit;

  assign fold      = VPN_W'(vpn_q[VPN_W-1:HALF]) ^ VPN_W'(vpn_q[HALF-1:0]);
  assign bkt       = fold[BKT_W-1:0];
  assign head_addr = TABLE_BASE + (32'(bkt) << 2);
  assign vpn_eq    = mem_rdata[VPN_W-1:0] == vpn_q;
  assign link_null = mem_rdata == 32'd0;
  assign at_limit  = hops_q == HOP_W'(MAX_HOPS);

  assign req_ready = st == S_IDLE;
  assign mem_req   = st != S_IDLE;

  always_comb begin
    case (st)
      S_HEAD:  mem_addr = head_addr;
      S_VPN:   mem_addr = ptr_q;
      S_PFN:   mem_addr = ptr_q + 32'd4;
      S_NEXT:  mem_addr = ptr_q + 32'd8;
      default: mem_addr = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      vpn_q      <= '0;
      ptr_q      <= '0;
      hops_q     <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_err   <= 1'b0;
      resp_pfn   <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          vpn_q  <= req_vpn;
          hops_q <= '0;
          st     <= S_HEAD;
        end
        S_HEAD, S_NEXT: if (mem_rvalid) begin
          if (link_null || at_limit) begin
            st         <= S_IDLE;
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_err   <= !link_null;
            resp_pfn   <= '0;
          end else begin
            ptr_q  <= mem_rdata;
            hops_q <= hops_q + 1'b1;
            st     <= S_VPN;
          end
        end
        S_VPN: if (mem_rvalid) st <= vpn_eq ? S_PFN : S_NEXT;
        S_PFN: if (mem_rvalid) begin
          st         <= S_IDLE;
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
          resp_err   <= 1'b0;
          resp_pfn   <= mem_rdata[PFN_W-1:0];
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && mem_req));

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r10_ready_at_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);

  a_r7_hit_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_hit && resp_err));

  a_r7_hop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hops_q <= HOP_W'(MAX_HOPS));

  a_r4_hit_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> $past(st == S_PFN && mem_rvalid));

endmodule

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int BW = 4;
  localparam int MAXH = 6;
  localparam logic [31:0] BASE = 32'h40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [VW-1:0] req_vpn = '0;
  logic resp_valid, resp_hit, resp_err;
  logic [PW-1:0] resp_pfn;
  logic mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_walker #(.VPN_W(VW), .PFN_W(PW), .BKT_W(BW), .MAX_HOPS(MAXH), .TABLE_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_err(resp_err), .resp_pfn(resp_pfn),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  logic [31:0] mem [0:1023];
  logic [31:0] rlog [0:4095];
  int nlog = 0;
  int lat = 0;
  int total = 0, bad = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      lat        <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req && !mem_rvalid) begin
        if (lat == 0) begin
          mem_rvalid       <= 1'b1;
          mem_rdata        <= mem[mem_addr[11:2]];
          rlog[nlog % 4096] <= mem_addr;
          nlog             <= nlog + 1;
          lat              <= int'($urandom % 3);
        end else lat <= lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] hashf(input logic [VW-1:0] v);
    return BW'(v[19:10] ^ v[9:0]);
  endfunction

  function automatic logic [VW-1:0] mkvpn(input int u, input int h);
    logic [9:0] hi;
    hi = 10'(u);
    return {hi, hi ^ 10'(h)};
  endfunction

  function automatic logic [31:0] eaddr(input int k);
    return 32'h100 + 32'(12 * k);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic put_elem(input int k, input logic [31:0] vw, input logic [31:0] fw, input logic [31:0] nx);
    mem[eaddr(k) >> 2]       = vw;
    mem[(eaddr(k) + 4) >> 2] = fw;
    mem[(eaddr(k) + 8) >> 2] = nx;
  endtask

  task automatic set_head(input int h, input logic [31:0] p);
    mem[(BASE + 32'(4 * h)) >> 2] = p;
  endtask

  logic ghit, gerr;
  logic [PW-1:0] gpfn;
  int gn;
  logic [31:0] gaddr [0:63];

  task automatic golden(input logic [VW-1:0] v);
    logic [31:0] a, p;
    int hops;
    bit done;
    ghit = 0; gerr = 0; gpfn = '0; gn = 0; hops = 0; done = 0;
    a = BASE + 32'(4 * int'(hashf(v)));
    gaddr[gn] = a; gn++;
    p = mem[a >> 2];
    while (!done) begin
      if (p == 0) done = 1;
      else if (hops == MAXH) begin gerr = 1; done = 1; end
      else begin
        hops++;
        gaddr[gn] = p; gn++;
        if (mem[p >> 2][VW-1:0] == v) begin
          gaddr[gn] = p + 4; gn++;
          ghit = 1;
          gpfn = mem[(p + 4) >> 2][PW-1:0];
          done = 1;
        end else begin
          gaddr[gn] = p + 8; gn++;
          p = mem[(p + 8) >> 2];
        end
      end
    end
  endtask

  task automatic lookup(input logic [VW-1:0] v, input string tag, input bit poke);
    int start, n, got;
    golden(v);
    @(negedge clk);
    n = 0;
    while (!req_ready && n < 400) begin @(negedge clk); n++; end
    start = nlog;
    req_valid = 1; req_vpn = v;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      req_valid = 1; req_vpn = v ^ 20'h00015;
      chk(req_ready == 0, {tag, " R8 ready low while busy"}, 64'(req_ready), 0);
      @(negedge clk);
      req_valid = 0;
    end
    n = 0;
    while (!resp_valid && n < 400) begin @(negedge clk); n++; end
    if (!resp_valid) begin
      chk(0, {tag, " R10 no response"}, 0, 1);
      return;
    end
    chk(resp_hit == ghit, {tag, " R4/R6 hit"}, 64'(resp_hit), 64'(ghit));
    chk(resp_err == gerr, {tag, " R7 err"}, 64'(resp_err), 64'(gerr));
    chk(resp_pfn == gpfn, {tag, " R4 frame"}, 64'(resp_pfn), 64'(gpfn));
    chk(req_ready == 1, {tag, " R10 ready with response"}, 64'(req_ready), 1);
    got = nlog - start;
    chk(got == gn, {tag, " R5 read count"}, 64'(got), 64'(gn));
    if (got > 0) chk(rlog[start % 4096] == gaddr[0], {tag, " R2 bucket address"}, 64'(rlog[start % 4096]), 64'(gaddr[0]));
    for (int i = 1; i < gn && i < got; i++)
      chk(rlog[(start + i) % 4096] == gaddr[i], {tag, " R3 element address"}, 64'(rlog[(start + i) % 4096]), 64'(gaddr[i]));
    @(negedge clk);
    chk(resp_valid == 0, {tag, " R10 pulse one cycle"}, 64'(resp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [VW-1:0] pool [0:39];

  initial begin
    void'($urandom(32'd4242));
    clear_mem();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1 && resp_valid == 0 && mem_req == 0, "R1 reset outputs", {req_ready, resp_valid, mem_req}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && resp_valid == 0 && mem_req == 0, "R1 after reset", {req_ready, resp_valid, mem_req}, 3'b100);

    lookup(mkvpn(1, 3), "R6 empty bucket", 0);

    for (int i = 0; i < 6; i++)
      put_elem(i, 32'(mkvpn(10 + i, 3)), 32'h000A_0000 + 32'(i), (i == 5) ? 32'd0 : eaddr(i + 1));
    set_head(3, eaddr(0));
    lookup(mkvpn(10, 3), "R4 first element", 1);
    lookup(mkvpn(13, 3), "R5 middle element", 0);
    lookup(mkvpn(15, 3), "R7 match at limit", 1);
    lookup(mkvpn(99, 3), "R6 null at limit", 0);

    mem[eaddr(0) >> 2]       = 32'hABC0_0000 | 32'(mkvpn(10, 3));
    mem[(eaddr(0) + 4) >> 2] = 32'hFFF1_2345;
    lookup(mkvpn(10, 3), "R3 upper bits ignored", 0);

    put_elem(6, 32'(mkvpn(16, 3)), 32'h0000_0777, 32'd0);
    mem[(eaddr(5) + 8) >> 2] = eaddr(6);
    lookup(mkvpn(16, 3), "R7 past limit", 1);
    lookup(mkvpn(98, 3), "R7 miss past limit", 0);

    put_elem(7, 32'(mkvpn(20, 5)), 32'h0000_0BEE, eaddr(7));
    set_head(5, eaddr(7));
    lookup(mkvpn(21, 5), "R7 circular chain", 1);
    lookup(mkvpn(20, 5), "R4 circular hit", 0);

    clear_mem();
    for (int k = 0; k < 40; k++) begin
      logic [VW-1:0] v;
      logic [31:0] hd;
      v = VW'($urandom);
      pool[k] = v;
      hd = mem[(BASE + 32'(4 * int'(hashf(v)))) >> 2];
      put_elem(k, 32'(v), $urandom, hd);
      set_head(int'(hashf(v)), eaddr(k));
    end
    for (int t = 0; t < 60; t++) begin
      logic [VW-1:0] v;
      if (t % 2 == 0) v = pool[$urandom % 40];
      else v = VW'($urandom);
      lookup(v, "R4/R6/R7 random", bit'(t % 3 == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule